// File: doc/BRIEF.md
# Programmable Pad Function Crossbar

This block is the routing matrix between a chip's external pads and its internal peripheral functions. Each pad owns a 32-bit configuration word. Its low byte picks one function out of the function space. The remaining fields decide three things: how that function's data and enables reach the pad, how the pad's input level returns to the function, and which electrical controls are forwarded to the pad cell. All function-to-pad and pad-to-function paths are combinational, so routing adds no latency.

A separate pair of tie banks can pin any function input to a constant. Software sets a function's tie-enable bit and gives the level in the matching tie-value bit, and the function then sees that level whatever the pads are doing. All configuration is reached through a simple word-addressed read/write port. The pad configuration words come first, then the tie-enable words, then the tie-value words, with one bit per function in the tie words.

Top module: `pfx_crossbar`

## Requirements
- R1: On a synchronous active-low reset every pad configuration word, every tie-enable bit, every tie-value bit and `bus_rdata` become zero.
- R2: Word addresses 0..NUM_PADS-1 hold the pad words. The next NUM_FUNCS/32 addresses hold tie-enable words, and the NUM_FUNCS/32 after those hold tie-value words, with function f at bit f%32 of word f/32. A write with `bus_we` takes effect at the clock edge. A read with `bus_re` presents the pre-edge contents on `bus_rdata` after that edge. `bus_rdata` is zero after any edge without `bus_re`. Unmapped words read zero and ignore writes.
- R3: Pad word bits 18 and 24..30 are not stored and read zero. A read of a pad word returns that pad's raw `pad_in` level, as sampled at the read edge, in bit 31.
- R4: Bits [7:0] select the function. When bit 14 is clear, the pad data output is that function's `func_do` XOR bit 15. A select value at or above NUM_FUNCS sees all function signals as 0.
- R5: The pad output enable equals bit 12 AND (bit 13 XOR the selected function's `func_oe`).
- R6: The pad input enable equals bit 20 AND (bit 21 XOR the selected function's `func_ie`).
- R7: When bit 14 is set, the pad data output is the computed pad output enable XOR bit 15.
- R8: Bits [11:8] drive the pad's 4-bit drive code. Bit 16 is pull-up, bit 17 is pull-down, bit 19 is slew reduction and bit 23 is Schmitt trigger, each forwarded to its own pad control output.
- R9: An untied function input carries `pad_in` XOR bit 22 of the lowest-numbered pad that has its computed input enable set and selects that function. It is 0 when no such pad exists.
- R10: A function whose tie-enable bit is 1 sees its tie-value bit on `func_di`, whatever the pad routing is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| func_do | input | NUM_FUNCS | Output data from each function |
| func_oe | input | NUM_FUNCS | Output enable from each function |
| func_ie | input | NUM_FUNCS | Input enable from each function |
| func_di | output | NUM_FUNCS | Input data delivered to each function |
| pad_in | input | NUM_PADS | Raw level seen at each pad |
| pad_do | output | NUM_PADS | Data driven to each pad |
| pad_oe | output | NUM_PADS | Output enable of each pad |
| pad_ie | output | NUM_PADS | Input enable of each pad |
| pad_drive | output | 4*NUM_PADS | Drive code, 4 bits per pad |
| pad_pu | output | NUM_PADS | Pull-up control |
| pad_pd | output | NUM_PADS | Pull-down control |
| pad_slew | output | NUM_PADS | Slew reduction control |
| pad_schmitt | output | NUM_PADS | Schmitt trigger control |

## Verification
The bench builds the crossbar with 8 pads, 64 functions and a 4-bit address. With those values random traffic lands on every pad word and both words of each tie bank. It also hits the unmapped words 12..15, and it produces select codes 64..255 that fall outside the function space. The small pad count makes it likely that several input-enabled pads claim the same function, which exercises the lowest-pad priority. Tie banks are toggled while those same functions are routed from pads.

// File: rtl/pfx_pkg.sv
// Package: field positions of the pad configuration word shared by the crossbar.
// Assumes 32-bit configuration words.
package pfx_pkg;
    localparam int CFG_W        = 32;
    localparam int B_SEL_LO     = 0;
    localparam int SEL_W        = 8;
    localparam int B_DRV_LO     = 8;
    localparam int DRV_W        = 4;
    localparam int B_OE_EN      = 12;
    localparam int B_OE_INV     = 13;
    localparam int B_DO_FROM_OE = 14;
    localparam int B_DO_INV     = 15;
    localparam int B_PULL_UP    = 16;
    localparam int B_PULL_DN    = 17;
    localparam int B_SLEW       = 19;
    localparam int B_IE_EN      = 20;
    localparam int B_IE_INV     = 21;
    localparam int B_DI_INV     = 22;
    localparam int B_SCHMITT    = 23;
    localparam int B_RAW_IN     = 31;
    localparam logic [CFG_W-1:0] CFG_WMASK = 32'h00FB_FFFF;
    localparam int TIE_BITS     = 32;
endpackage

// File: rtl/pfx_regs.sv
// Module: configuration and tie register file with a one-cycle registered read.
// Assumes NUM_FUNCS is a multiple of 32 and ADDR_W reaches every mapped word.
module pfx_regs
    import pfx_pkg::*;
#(
    parameter int NUM_PADS  = 48,
    parameter int NUM_FUNCS = 256,
    parameter int ADDR_W    = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic                                re,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [CFG_W-1:0]                    wdata,
    input  logic [NUM_PADS-1:0]                 pad_in,
    output logic [CFG_W-1:0]                    rdata,
    output logic [NUM_PADS-1:0][CFG_W-1:0]      cfg,
    output logic [NUM_FUNCS-1:0]                tie_en,
    output logic [NUM_FUNCS-1:0]                tie_val
);
    localparam int TIE_WORDS = NUM_FUNCS / TIE_BITS;
    localparam int TEN_BASE  = NUM_PADS;
    localparam int TVAL_BASE = NUM_PADS + TIE_WORDS;

    logic [CFG_W-1:0] rd_next;

    // Read mux: select the addressed word, zero for unmapped addresses.
    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NUM_PADS; p++)
            if (int'(addr) == p) begin
                rd_next = cfg[p];
                rd_next[B_RAW_IN] = pad_in[p];
            end
        for (int w = 0; w < TIE_WORDS; w++) begin
            if (int'(addr) == TEN_BASE + w)  rd_next = tie_en[w*TIE_BITS +: TIE_BITS];
            if (int'(addr) == TVAL_BASE + w) rd_next = tie_val[w*TIE_BITS +: TIE_BITS];
        end
    end

    // Register update: reset, masked pad writes, tie word writes, read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg     <= '0;
            tie_en  <= '0;
            tie_val <= '0;
            rdata   <= '0;
        end else begin
            if (we) begin
                for (int p = 0; p < NUM_PADS; p++)
                    if (int'(addr) == p) cfg[p] <= wdata & CFG_WMASK;
                for (int w = 0; w < TIE_WORDS; w++) begin
                    if (int'(addr) == TEN_BASE + w)  tie_en[w*TIE_BITS +: TIE_BITS]  <= wdata;
                    if (int'(addr) == TVAL_BASE + w) tie_val[w*TIE_BITS +: TIE_BITS] <= wdata;
                end
            end
            rdata <= re ? rd_next : '0;
        end
    end

    // R1: the cycle after reset the read data is clear.
    p_rdata_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> rdata == '0);

    // R2: without a read strobe the read data returns to zero.
    p_rdata_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(re) |-> rdata == '0);

    // R3: a pad word read never shows the unstored bits.
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(re) && $past(int'(addr) < NUM_PADS)
        |-> (rdata[30:24] == '0 && rdata[18] == 1'b0));
endmodule

// File: rtl/pfx_pad_slice.sv
// Module: output side of one pad; picks its function and applies enables,
// inversions and electrical controls. Assumes select codes beyond NUM_FUNCS
// see all function signals low.
module pfx_pad_slice
    import pfx_pkg::*;
#(
    parameter int NUM_FUNCS = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg,
    input  logic [NUM_FUNCS-1:0] func_do,
    input  logic [NUM_FUNCS-1:0] func_oe,
    input  logic [NUM_FUNCS-1:0] func_ie,
    output logic                 pad_do,
    output logic                 pad_oe,
    output logic                 pad_ie,
    output logic [DRV_W-1:0]     pad_drive,
    output logic                 pad_pu,
    output logic                 pad_pd,
    output logic                 pad_slew,
    output logic                 pad_schmitt
);
    localparam int FSEL_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

    logic              sel_ok;
    logic [FSEL_W-1:0] idx;
    logic              f_do, f_oe, f_ie, data_pre;

    // Function lookup: fetch the selected function's three signals.
    always_comb begin
        sel_ok = int'(cfg[B_SEL_LO +: SEL_W]) < NUM_FUNCS;
        idx    = cfg[FSEL_W-1:0];
        f_do   = sel_ok ? func_do[idx] : 1'b0;
        f_oe   = sel_ok ? func_oe[idx] : 1'b0;
        f_ie   = sel_ok ? func_ie[idx] : 1'b0;
    end

    // Enables and data: gated enables, optional enable-as-data, final inversion.
    always_comb begin
        pad_oe   = cfg[B_OE_EN] & (cfg[B_OE_INV] ^ f_oe);
        pad_ie   = cfg[B_IE_EN] & (cfg[B_IE_INV] ^ f_ie);
        data_pre = cfg[B_DO_FROM_OE] ? pad_oe : f_do;
        pad_do   = data_pre ^ cfg[B_DO_INV];
    end

    // Electrical controls: forwarded straight from the stored word.
    always_comb begin
        pad_drive   = cfg[B_DRV_LO +: DRV_W];
        pad_pu      = cfg[B_PULL_UP];
        pad_pd      = cfg[B_PULL_DN];
        pad_slew    = cfg[B_SLEW];
        pad_schmitt = cfg[B_SCHMITT];
    end

    // R5: a pad with its output gate clear never drives.
    p_oe_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[B_OE_EN] |-> !pad_oe);

    // R6: a pad with its input gate clear never listens.
    p_ie_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg[B_IE_EN] |-> !pad_ie);
endmodule

// File: rtl/pfx_in_route.sv
// Module: input side of the crossbar; scatters pad levels onto function inputs
// with lowest-pad priority, then applies the tie override.
// Assumes pad_ie already holds each pad's computed input enable.
module pfx_in_route
    import pfx_pkg::*;
#(
    parameter int NUM_PADS  = 48,
    parameter int NUM_FUNCS = 256
) (
    input  logic [NUM_PADS-1:0][SEL_W-1:0] sel,
    input  logic [NUM_PADS-1:0]            di_inv,
    input  logic [NUM_PADS-1:0]            pad_ie,
    input  logic [NUM_PADS-1:0]            pad_in,
    input  logic [NUM_FUNCS-1:0]           tie_en,
    input  logic [NUM_FUNCS-1:0]           tie_val,
    output logic [NUM_FUNCS-1:0]           func_di
);
    localparam int FSEL_W = (NUM_FUNCS > 1) ? $clog2(NUM_FUNCS) : 1;

    logic [NUM_FUNCS-1:0] hit;
    logic [NUM_FUNCS-1:0] lvl;

    // Scatter: walk pads from highest to lowest so the lowest one writes last.
    always_comb begin
        hit = '0;
        lvl = '0;
        for (int p = NUM_PADS - 1; p >= 0; p--)
            if (pad_ie[p] && int'(sel[p]) < NUM_FUNCS) begin
                hit[sel[p][FSEL_W-1:0]] = 1'b1;
                lvl[sel[p][FSEL_W-1:0]] = pad_in[p] ^ di_inv[p];
            end
    end

    // Tie override: a tied function takes its tie level, an unrouted one reads 0.
    always_comb func_di = (tie_en & tie_val) | (~tie_en & hit & lvl);
endmodule

// File: rtl/pfx_crossbar.sv
// Module: top of the pad function crossbar. Holds the register file, one output
// slice per pad and the input router. Assumes NUM_FUNCS is a multiple of 32 and
// at most 256 (8-bit select field).
module pfx_crossbar
    import pfx_pkg::*;
#(
    parameter int NUM_PADS  = 48,
    parameter int NUM_FUNCS = 256,
    parameter int ADDR_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic                      bus_re,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    input  logic [NUM_FUNCS-1:0]      func_do,
    input  logic [NUM_FUNCS-1:0]      func_oe,
    input  logic [NUM_FUNCS-1:0]      func_ie,
    output logic [NUM_FUNCS-1:0]      func_di,
    input  logic [NUM_PADS-1:0]       pad_in,
    output logic [NUM_PADS-1:0]       pad_do,
    output logic [NUM_PADS-1:0]       pad_oe,
    output logic [NUM_PADS-1:0]       pad_ie,
    output logic [4*NUM_PADS-1:0]     pad_drive,
    output logic [NUM_PADS-1:0]       pad_pu,
    output logic [NUM_PADS-1:0]       pad_pd,
    output logic [NUM_PADS-1:0]       pad_slew,
    output logic [NUM_PADS-1:0]       pad_schmitt
);
    logic [NUM_PADS-1:0][CFG_W-1:0] cfg;
    logic [NUM_FUNCS-1:0]           tie_en, tie_val;
    logic [NUM_PADS-1:0][SEL_W-1:0] sel;
    logic [NUM_PADS-1:0]            di_inv;

    pfx_regs #(.NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(bus_we), .re(bus_re), .addr(bus_addr),
        .wdata(bus_wdata), .pad_in(pad_in), .rdata(bus_rdata), .cfg(cfg),
        .tie_en(tie_en), .tie_val(tie_val)
    );

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        pfx_pad_slice #(.NUM_FUNCS(NUM_FUNCS)) u_slice (
            .clk(clk), .rst_n(rst_n), .cfg(cfg[p]),
            .func_do(func_do), .func_oe(func_oe), .func_ie(func_ie),
            .pad_do(pad_do[p]), .pad_oe(pad_oe[p]), .pad_ie(pad_ie[p]),
            .pad_drive(pad_drive[p*DRV_W +: DRV_W]), .pad_pu(pad_pu[p]),
            .pad_pd(pad_pd[p]), .pad_slew(pad_slew[p]), .pad_schmitt(pad_schmitt[p])
        );
        assign sel[p]    = cfg[p][B_SEL_LO +: SEL_W];
        assign di_inv[p] = cfg[p][B_DI_INV];
    end

    pfx_in_route #(.NUM_PADS(NUM_PADS), .NUM_FUNCS(NUM_FUNCS)) u_route (
        .sel(sel), .di_inv(di_inv), .pad_ie(pad_ie), .pad_in(pad_in),
        .tie_en(tie_en), .tie_val(tie_val), .func_di(func_di)
    );

    // R9: with no listening pad and no tie, every function input reads 0.
    p_untied_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_ie == '0 && tie_en == '0) |-> func_di == '0);
endmodule

// File: tb/pfx_crossbar_tb.sv
// Bench: behavioural reference model of the crossbar, compared on every clock.
module pfx_crossbar_tb;
    localparam int NP = 8;
    localparam int NF = 64;
    localparam int AW = 4;
    localparam int TW = NF / 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_we = 1'b0, bus_re = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NF-1:0] func_do = '0, func_oe = '0, func_ie = '0, func_di;
    logic [NP-1:0] pad_in = '0, pad_do, pad_oe, pad_ie, pad_pu, pad_pd, pad_slew, pad_schmitt;
    logic [4*NP-1:0] pad_drive;

    pfx_crossbar #(.NUM_PADS(NP), .NUM_FUNCS(NF), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .func_do(func_do), .func_oe(func_oe),
        .func_ie(func_ie), .func_di(func_di), .pad_in(pad_in), .pad_do(pad_do),
        .pad_oe(pad_oe), .pad_ie(pad_ie), .pad_drive(pad_drive), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_slew(pad_slew), .pad_schmitt(pad_schmitt)
    );

    always #4 clk = ~clk;

    int checks = 0, errors = 0;
    string phase = "R1 reset";
    logic [31:0] m_cfg [NP];
    logic [NF-1:0] m_ten = '0, m_tval = '0;
    logic [31:0] exp_rd = '0;

    task automatic chk(string what, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] actual=%h expected=%h", what, phase, act, exp);
        end
    endtask

    // Compare every output against the model at the falling edge, then advance the model.
    task automatic tick();
        logic [NP-1:0] e_do, e_oe, e_ie, e_pu, e_pd, e_sl, e_st;
        logic [4*NP-1:0] e_drv;
        logic [NF-1:0] e_di;
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            logic [31:0] c;
            int s;
            logic fo, fd, fi, d;
            c = m_cfg[p];
            s = int'(c[7:0]);
            fo = (s < NF) ? func_oe[s] : 1'b0;
            fd = (s < NF) ? func_do[s] : 1'b0;
            fi = (s < NF) ? func_ie[s] : 1'b0;
            e_oe[p] = c[12] && (c[13] != fo);
            e_ie[p] = c[20] && (c[21] != fi);
            d = c[14] ? e_oe[p] : fd;
            e_do[p] = d ^ c[15];
            e_drv[p*4 +: 4] = c[11:8];
            e_pu[p] = c[16]; e_pd[p] = c[17]; e_sl[p] = c[19]; e_st[p] = c[23];
        end
        for (int f = 0; f < NF; f++) begin
            e_di[f] = 1'b0;
            if (m_ten[f]) e_di[f] = m_tval[f];
            else begin
                bit found = 0;
                for (int p = 0; p < NP; p++)
                    if (!found && e_ie[p] && int'(m_cfg[p][7:0]) == f) begin
                        found = 1;
                        e_di[f] = pad_in[p] ^ m_cfg[p][22];
                    end
            end
        end
        chk("bus_rdata R2 R3", 128'(bus_rdata), 128'(exp_rd));
        chk("pad_do R4 R7", 128'(pad_do), 128'(e_do));
        chk("pad_oe R5", 128'(pad_oe), 128'(e_oe));
        chk("pad_ie R6", 128'(pad_ie), 128'(e_ie));
        chk("pad controls R8", {pad_drive, pad_pu, pad_pd, pad_slew, pad_schmitt},
            {e_drv, e_pu, e_pd, e_sl, e_st});
        chk("func_di R9 R10", 128'(func_di), 128'(e_di));
        @(posedge clk);
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) m_cfg[p] = '0;
            m_ten = '0; m_tval = '0; exp_rd = '0;
        end else begin
            int a;
            a = int'(bus_addr);
            exp_rd = '0;
            if (bus_re) begin
                if (a < NP) begin exp_rd = m_cfg[a]; exp_rd[31] = pad_in[a]; end
                else if (a < NP + TW) exp_rd = m_ten[(a-NP)*32 +: 32];
                else if (a < NP + 2*TW) exp_rd = m_tval[(a-NP-TW)*32 +: 32];
            end
            if (bus_we) begin
                if (a < NP) m_cfg[a] = bus_wdata & 32'h00FB_FFFF;
                else if (a < NP + TW) m_ten[(a-NP)*32 +: 32] = bus_wdata;
                else if (a < NP + 2*TW) m_tval[(a-NP-TW)*32 +: 32] = bus_wdata;
            end
        end
        #1;
    endtask

    task automatic wr(int a, logic [31:0] d);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        tick();
        bus_we = 1'b0;
    endtask

    task automatic rd(int a);
        bus_re = 1'b1; bus_addr = AW'(a);
        tick();
        bus_re = 1'b0;
    endtask

    task automatic rand_funcs();
        func_do = {$urandom, $urandom};
        func_oe = {$urandom, $urandom};
        func_ie = {$urandom, $urandom};
        pad_in  = NP'($urandom);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired [%s] actual=running expected=finished", phase);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int p = 0; p < NP; p++) m_cfg[p] = '0;
        // R1: reset clears everything; then every address reads zero.
        phase = "R1 reset";
        rand_funcs();
        for (int i = 0; i < 3; i++) tick();
        rst_n = 1'b1;
        pad_in = '0;
        for (int a = 0; a < 16; a++) rd(a);
        tick();

        // R2 R3: register map, write mask, raw input bit, unmapped words.
        phase = "R2 R3 map";
        pad_in = 8'h01;
        wr(0, 32'hFFFF_FFFF); rd(0);
        wr(1, 32'h0000_0000); pad_in = 8'h02; rd(1);
        wr(NP, 32'hA5A5_0001); wr(NP + TW + 1, 32'h1234_5678);
        wr(12, 32'hDEAD_BEEF); wr(15, 32'hFFFF_FFFF);
        for (int a = 0; a < 16; a++) rd(a);
        tick();

        // R4 R5 R6 R7 R8: assorted pad words under random function traffic.
        phase = "R4 R5 R6 R7 R8 pad side";
        wr(0, 32'h0000_1003);
        wr(1, 32'h0000_3003);
        wr(2, 32'h0000_5007);
        wr(3, 32'h0030_B046);
        wr(4, 32'h008B_0520);
        wr(5, 32'h0010_C0FF);
        wr(6, 32'h0031_F03F);
        wr(7, 32'h0002_0700);
        for (int i = 0; i < 200; i++) begin rand_funcs(); tick(); end

        // R9: two listening pads on one function; the lower pad must win.
        phase = "R9 lowest pad wins";
        for (int p = 0; p < NP; p++) wr(p, 32'h0);
        wr(2, 32'h0010_0009);
        wr(5, 32'h0050_0009);
        wr(6, 32'h0030_000A);
        for (int i = 0; i < 200; i++) begin rand_funcs(); tick(); end

        // R10: tie override on routed functions.
        phase = "R10 tie override";
        wr(NP, 32'h0000_0600); wr(NP + TW, 32'h0000_0200);
        for (int i = 0; i < 100; i++) begin rand_funcs(); tick(); end
        wr(NP + TW, 32'h0000_0400);
        for (int i = 0; i < 100; i++) begin rand_funcs(); tick(); end

        // R2 mixed: random bus traffic over all 16 addresses with random pads.
        phase = "R2 R4 R9 R10 random";
        for (int i = 0; i < 3000; i++) begin
            rand_funcs();
            bus_we = ($urandom % 3) == 0;
            bus_re = ($urandom % 2) == 0;
            bus_addr = AW'($urandom);
            bus_wdata = $urandom;
            if ($urandom % 2 == 0) bus_wdata[7:0] = 8'($urandom % 80);
            tick();
        end
        bus_we = 1'b0; bus_re = 1'b0;
        tick(); tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule